// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptance Controller

This block serves one DMA channel in single address mode. It takes an active-low request pin from an external device and turns each activation into exactly one single transfer. When the channel is enabled and idle, a low level on the pin latches a request. The block then raises a bus request and waits for the bus arbiter to grant the bus. On the grant it clears the latched request, runs one transfer cycle and drives an active-low acknowledge strobe to the device for that cycle.

After each transfer the block stays disarmed until it has seen the pin high. A device that holds the pin low therefore cannot start a second transfer. Before the pin is sampled it passes through a synchronizer chain. A grant is taken only after the request has been held for a minimum number of cycles. Address generation, transfer counting and the data path are handled by other blocks.

Top module: `dma_edge_req_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, bus_req_o is 0, dack_no is 1 and busy_o is 0.
- R2: The request pin passes through a two-stage synchronizer. With the channel enabled and the block idle, a pin driven low before rising edge k makes bus_req_o 1 after rising edge k+2, and not before.
- R3: A grant is accepted only after the request has been held for MIN_GAP cycles (default 2). With the grant held high from the start, the transfer begins two rising edges after bus_req_o rises.
- R4: bus_req_o stays 1 until a grant is accepted. On the edge where the grant is accepted, bus_req_o drops to 0 and the transfer cycle begins.
- R5: During the transfer cycle dack_no is 0 when ack_en_i is 1, and 1 when ack_en_i is 0. Outside the transfer cycle dack_no is always 1.
- R6: The transfer cycle ends on the rising edge where xfer_done_i is sampled 1, and dack_no returns to 1 after that edge.
- R7: If no high level was seen on the synchronized pin between the start of the transfer and its end, the block stays busy and raises no new bus request for as long as the pin stays low.
- R8: If a high level was sampled during the transfer, the block returns to idle on the same edge that ends the transfer (busy_o 0 after that edge).
- R9: Once a high level has been sampled after a transfer, the block returns to idle. A low level sampled after that latches a new request under the same rule as R2.
- R10: When chan_en_i is 0 at a rising edge, the block returns to idle, dropping bus_req_o and dack_no. While chan_en_i stays 0, a low pin raises no request.
- R11: busy_o is 1 exactly when the block is not idle: while a request is held, while a transfer runs, or while it waits for the pin to go high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the pin is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dreq_ni | input | 1 | External active-low DMA request pin |
| chan_en_i | input | 1 | Channel transfer enable |
| ack_en_i | input | 1 | Enables the acknowledge strobe during transfers |
| bus_grant_i | input | 1 | Bus granted to the DMA channel |
| xfer_done_i | input | 1 | Current single transfer cycle has finished |
| bus_req_o | output | 1 | Bus request toward the arbiter |
| dack_no | output | 1 | Active-low transfer acknowledge to the device |
| busy_o | output | 1 | Block is not idle |

## Verification
The assertions check on every cycle that the acknowledge is never active while ack_en_i is 0 and that a disabled channel is idle one edge later. They also check that a new request can only come from the idle state, that a transfer starts only after the hold timer has expired, and that the re-arm flag, once set, stays set until the next transfer clears it. The bench scenarios show the things that depend on the exact cycle and on the order of events. These are the three-edge latency through the synchronizer and the exact two-cycle hold before a grant is taken. They also include refusing to retrigger on a pin held low, returning straight to idle when the pin rose during the transfer, and re-arming with the same latency after the pin goes high.

// File: rtl/dma_edge_req_pkg.sv
package dma_edge_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_WAIT = 2'd3
  } req_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] chain_q;

  // reset to the inactive (high) pin level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= pin_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/req_gap_timer.sv
module req_gap_timer #(
  parameter int unsigned MIN_GAP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic gap_ok_o
);
  localparam int unsigned LIMIT = (MIN_GAP > 0) ? MIN_GAP - 1 : 0;
  localparam int unsigned CW    = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_ok_o = run_i && (cnt_q == LIM_V);

  a_r3_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_V);
  a_r3_clear_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/rearm_tracker.sv
module rearm_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic pin_high_i,
  output logic rearm_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_q <= 1'b0;
    else if (clear_i)                 seen_q <= 1'b0;
    else if (sample_i && pin_high_i)  seen_q <= 1'b1;
  end

  assign rearm_o = seen_q || (sample_i && pin_high_i);

  a_r8_seen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !clear_i) |=> seen_q);
endmodule

// File: rtl/dma_edge_req_ctrl.sv
module dma_edge_req_ctrl
  import dma_edge_req_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_GAP     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_ni,
  input  logic chan_en_i,
  input  logic ack_en_i,
  input  logic bus_grant_i,
  input  logic xfer_done_i,
  output logic bus_req_o,
  output logic dack_no,
  output logic busy_o
);
  req_state_e state_q, state_d;
  logic pin_s, gap_ok, rearm, xfer_start;

  dreq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (dreq_ni),
    .pin_o  (pin_s)
  );

  req_gap_timer #(.MIN_GAP(MIN_GAP)) i_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_REQ),
    .gap_ok_o (gap_ok)
  );

  assign xfer_start = (state_q == ST_REQ) && bus_grant_i && gap_ok;

  rearm_tracker i_rearm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (xfer_start),
    .sample_i   ((state_q == ST_XFER) || (state_q == ST_WAIT)),
    .pin_high_i (pin_s),
    .rearm_o    (rearm)
  );

  always_comb begin
    state_d = state_q;
    if (!chan_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!pin_s)     state_d = ST_REQ;
        ST_REQ:  if (xfer_start) state_d = ST_XFER;
        ST_XFER: if (xfer_done_i) state_d = rearm ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (rearm)      state_d = ST_IDLE;
        default:                 state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign bus_req_o = (state_q == ST_REQ);
  assign dack_no   = !((state_q == ST_XFER) && ack_en_i);
  assign busy_o    = (state_q != ST_IDLE);

  a_r3_gap_before_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && $past(state_q) == ST_REQ) |-> $past(gap_ok));
  a_r7_req_only_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(state_q) == ST_IDLE);
  a_r5_ack_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_no |-> (ack_en_i && busy_o && !bus_req_o));
  a_r10_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> (!busy_o && !bus_req_o && dack_no));
endmodule

// File: tb/test_dma_edge_req_ctrl.sv
module test_dma_edge_req_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dreq_n = 1'b1, chan_en = 1'b0, ack_en = 1'b0, grant = 1'b0, done = 1'b0;
  logic bus_req, dack_n, busy;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_edge_req_ctrl i_dma_edge_req_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dreq_ni     (dreq_n),
    .chan_en_i   (chan_en),
    .ack_en_i    (ack_en),
    .bus_grant_i (grant),
    .xfer_done_i (done),
    .bus_req_o   (bus_req),
    .dack_no     (dack_n),
    .busy_o      (busy)
  );

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 bus_req in reset", bus_req, 1'b0);
    check("R1 dack_n in reset", dack_n, 1'b1);
    tick(2);
    rst_n = 1'b1;
    tick();
    check("R1 bus_req after reset", bus_req, 1'b0);
    check("R1 dack_n after reset", dack_n, 1'b1);
    check("R1 busy after reset", busy, 1'b0);
  endtask

  task automatic t_basic;
    chan_en = 1; ack_en = 1; grant = 1; dreq_n = 0;
    tick(2);
    check("R2 no request before sync", bus_req, 1'b0);
    tick();
    check("R2 request latched", bus_req, 1'b1);
    check("R11 busy while request", busy, 1'b1);
    tick();
    check("R3 grant ignored in first cycle", bus_req, 1'b1);
    check("R3 no ack before gap", dack_n, 1'b1);
    tick();
    check("R4 request cleared at grant", bus_req, 1'b0);
    check("R5 ack low in transfer", dack_n, 1'b0);
    tick();
    check("R6 ack held until done", dack_n, 1'b0);
    done = 1; tick(); done = 0;
    check("R6 ack released at done", dack_n, 1'b1);
    check("R7 busy with pin held low", busy, 1'b1);
    tick(10);
    check("R7 no retrigger while low", bus_req, 1'b0);
    check("R7 still busy while low", busy, 1'b1);
    dreq_n = 1;
    tick(2);
    check("R9 busy until high synced", busy, 1'b1);
    tick();
    check("R9 idle after high sampled", busy, 1'b0);
    dreq_n = 0;
    tick(2);
    check("R9 rearm same latency, not early", bus_req, 1'b0);
    tick();
    check("R9 new request after rearm", bus_req, 1'b1);
    tick(2);
    check("R5 second transfer ack", dack_n, 1'b0);
    dreq_n = 1;
    tick(3);
    done = 1; tick(); done = 0;
    check("R8 straight to idle at done", busy, 1'b0);
    check("R8 ack released", dack_n, 1'b1);
    tick(3);
    check("R8 no new request after idle", bus_req, 1'b0);
  endtask

  task automatic t_noack;
    ack_en = 0; grant = 0; dreq_n = 0;
    tick(3);
    check("R2 request with ack disabled", bus_req, 1'b1);
    tick(5);
    check("R4 request held without grant", bus_req, 1'b1);
    check("R4 no ack without grant", dack_n, 1'b1);
    grant = 1; dreq_n = 1;
    tick();
    check("R4 grant after wait clears request", bus_req, 1'b0);
    check("R5 ack stays high when disabled", dack_n, 1'b1);
    check("R11 busy in transfer", busy, 1'b1);
    tick(3);
    done = 1; tick(); done = 0;
    check("R8 idle after done", busy, 1'b0);
    grant = 0;
  endtask

  task automatic t_disable;
    ack_en = 1; dreq_n = 0;
    tick(3);
    check("R2 request before disable", bus_req, 1'b1);
    chan_en = 0;
    tick();
    check("R10 request dropped", bus_req, 1'b0);
    check("R10 idle after disable", busy, 1'b0);
    tick(5);
    check("R10 low pin ignored while disabled", bus_req, 1'b0);
    chan_en = 1;
    tick();
    check("R10 request after re-enable", bus_req, 1'b1);
    grant = 1;
    tick(2);
    check("R5 ack in transfer", dack_n, 1'b0);
    chan_en = 0;
    tick();
    check("R10 ack dropped on disable", dack_n, 1'b1);
    check("R10 idle from transfer", busy, 1'b0);
    dreq_n = 1; grant = 0;
    tick(3);
    chan_en = 1;
  endtask

  initial begin
    tick();
    t_reset();
    t_basic();
    t_noack();
    t_disable();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule